// File: doc/BRIEF.md
# Trim DAC Calibration Loader

This block brings the analog trim settings of a board back to their calibrated state after power-up and also lets software adjust one trim channel at a time while the system is running. A load request makes it walk through all eleven logical trim channels in ascending order. For each channel it reads one calibration byte from a simple byte-read port that represents a non-volatile memory. It then translates the logical channel into the physical channel number that the trim converter expects and assembles a 32-bit serial word.

Each word is passed to a serial converter transmitter through a request/done handshake, together with a plan that says which converter select goes with each byte pair. The two bytes that carry the trim address and value go to the trim converter. The two trailing zero bytes are sent to main converter 0 as a harmless no-op, so that the serial clock keeps running past the end of the real data. A readback register for each logical channel holds the last value written to it, and that value can be read through a select input.

Top module: `trim_cal_loader`

## Requirements
- R1: After reset, busy, rom_rd and tx_req are 0 and every readback register reads 0.
- R2: A load reads the byte-read port once for each logical channel, in the order 0 to 10. Each read is a one-cycle rom_rd pulse. The addresses are 0x40, 0x41, 0x42 for channels 0 to 2, 0x50 to 0x53 for channels 3 to 6, and 0x60 to 0x63 for channels 7 to 10.
- R3: The transmitted word is {16'h0000, 4'h0, phys, data}. Bits [11:8] hold the physical channel and bits [7:0] the setpoint. Logical channels 0 to 10 map to physical channels 10, 9, 8, 3, 2, 7, 6, 1, 0, 5, 4.
- R4: While tx_req is high, tx_sel_first is 2'b01 (trim converter, for word bytes [15:8] and then [7:0]) and tx_sel_last is 2'b10 (main converter 0, for bytes [31:24] and then [23:16]).
- R5: Once raised, tx_req stays high with a stable word until tx_done is sampled, and it drops in the next cycle. Only one request is ever outstanding. No byte read happens while a request is open.
- R6: busy rises in the cycle after an accepted load request and stays high until the eleventh tx_done. It is low in the following cycle. A load issues exactly eleven transmitter requests.
- R7: load_req and wr_req that arrive while busy is high are ignored. They start no extra transmitter request and no extra read.
- R8: A wr_req while idle with wr_chan below 11 issues exactly one transmitter request carrying wr_data for that channel, and it performs no byte read.
- R9: A wr_req with wr_chan of 11 or more is ignored. busy stays low, no request is issued and no readback register changes.
- R10: A readback register takes the new setpoint when its trim write is issued: when a single write is accepted, or when the byte for that channel arrives during a load. rb_data shows the register selected by rb_sel, and reads 0 for a select of 11 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_req | input | 1 | Start a full load of all eleven channels |
| wr_req | input | 1 | Single trim write request |
| wr_chan | input | 4 | Logical channel for a single write |
| wr_data | input | 8 | Setpoint for a single write |
| busy | output | 1 | An operation is in progress |
| rom_rd | output | 1 | One-cycle byte read strobe |
| rom_addr | output | 8 | Byte read address |
| rom_valid | input | 1 | Read data valid |
| rom_rdata | input | 8 | Read data |
| tx_req | output | 1 | Transmitter request, held until done |
| tx_word | output | 32 | Serial word for the transmitter |
| tx_sel_first | output | 2 | Select code for the first byte pair |
| tx_sel_last | output | 2 | Select code for the trailing byte pair |
| tx_done | input | 1 | Transmitter finished the word |
| rb_sel | input | 4 | Readback channel select |
| rb_data | output | 8 | Readback value of the selected channel |

## Verification
The bench builds the block with its default package widths: 8-bit setpoints, 8-bit byte addresses and 4-bit channel indices. These widths give the full eleven-entry channel map, every read address and the out-of-range channel codes 11 to 15. The memory and transmitter models answer after random latencies, including zero-wait done, so the hold and ordering rules of the handshake are tested under changing timing. Setpoint values cover random bytes as well as 0x00 and 0xFF.

// File: rtl/trim_pkg.sv
package trim_pkg;
  localparam int NUM_CH  = 11;
  localparam int CH_W    = 4;
  localparam int TRIM_DW = 8;
  localparam int ROM_AW  = 8;
  localparam int WORD_W  = 32;
  localparam int PHYS_W  = 4;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'b00,
    SEL_TRIM  = 2'b01,
    SEL_MAIN0 = 2'b10
  } dac_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_SEND
  } seq_state_e;

  // logical trim channel -> physical address inside the trim converter
  function automatic logic [PHYS_W-1:0] trim_phys(input logic [CH_W-1:0] lch);
    case (lch)
      4'd0:    return 4'd10;
      4'd1:    return 4'd9;
      4'd2:    return 4'd8;
      4'd3:    return 4'd3;
      4'd4:    return 4'd2;
      4'd5:    return 4'd7;
      4'd6:    return 4'd6;
      4'd7:    return 4'd1;
      4'd8:    return 4'd0;
      4'd9:    return 4'd5;
      4'd10:   return 4'd4;
      default: return 4'd15;
    endcase
  endfunction

  // logical trim channel -> calibration byte address
  function automatic logic [ROM_AW-1:0] trim_rom_addr(input logic [CH_W-1:0] lch);
    case (lch)
      4'd0:    return 8'h40;
      4'd1:    return 8'h41;
      4'd2:    return 8'h42;
      4'd3:    return 8'h50;
      4'd4:    return 8'h51;
      4'd5:    return 8'h52;
      4'd6:    return 8'h53;
      4'd7:    return 8'h60;
      4'd8:    return 8'h61;
      4'd9:    return 8'h62;
      4'd10:   return 8'h63;
      default: return 8'h00;
    endcase
  endfunction

  // upper half and trailing byte pair stay zero: the no-op for main converter 0
  function automatic logic [WORD_W-1:0] trim_word(input logic [PHYS_W-1:0] phys,
                                                  input logic [TRIM_DW-1:0] data);
    logic [WORD_W-1:0] w;
    w = '0;
    w[TRIM_DW +: PHYS_W] = phys;
    w[TRIM_DW-1:0]       = data;
    return w;
  endfunction
endpackage

// File: rtl/trim_seq.sv
module trim_seq
  import trim_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_req,
  input  logic               wr_req,
  input  logic [CH_W-1:0]    wr_chan,
  input  logic [TRIM_DW-1:0] wr_data,
  output logic               rom_rd,
  output logic [ROM_AW-1:0]  rom_addr,
  input  logic               rom_valid,
  input  logic [TRIM_DW-1:0] rom_rdata,
  output logic               tx_req,
  input  logic               tx_done,
  output logic [CH_W-1:0]    cur_chan,
  output logic [TRIM_DW-1:0] cur_data,
  output logic               busy,
  output logic               rb_we,
  output logic [CH_W-1:0]    rb_idx,
  output logic [TRIM_DW-1:0] rb_din
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  seq_state_e state_q;
  logic       load_mode_q;

  // named events
  logic accept_load, accept_wr, wr_chan_ok, byte_arrive, tx_finish, last_chan, step_next;

  assign wr_chan_ok  = (wr_chan <= LAST_CH);
  assign accept_load = (state_q == ST_IDLE) && load_req;
  assign accept_wr   = (state_q == ST_IDLE) && !load_req && wr_req && wr_chan_ok;
  assign byte_arrive = (state_q == ST_WAIT) && rom_valid;
  assign tx_finish   = (state_q == ST_SEND) && tx_done;
  assign last_chan   = (cur_chan == LAST_CH);
  assign step_next   = tx_finish && load_mode_q && !last_chan;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      load_mode_q <= 1'b0;
      cur_chan    <= '0;
      cur_data    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_load) begin
            load_mode_q <= 1'b1;
            cur_chan    <= '0;
            state_q     <= ST_FETCH;
          end else if (accept_wr) begin
            load_mode_q <= 1'b0;
            cur_chan    <= wr_chan;
            cur_data    <= wr_data;
            state_q     <= ST_SEND;
          end
        end
        ST_FETCH: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (byte_arrive) begin
            cur_data <= rom_rdata;
            state_q  <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (step_next) begin
            cur_chan <= cur_chan + 1'b1;
            state_q  <= ST_FETCH;
          end else if (tx_finish) begin
            load_mode_q <= 1'b0;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign rom_rd   = (state_q == ST_FETCH);
  assign rom_addr = trim_rom_addr(cur_chan);
  assign tx_req   = (state_q == ST_SEND);

  assign rb_we  = accept_wr || byte_arrive;
  assign rb_idx = accept_wr ? wr_chan : cur_chan;
  assign rb_din = accept_wr ? wr_data : rom_rdata;

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_done |=> tx_req && $stable(cur_chan) && $stable(cur_data));

  // R5
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_done |=> !tx_req);

  // R2
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> !rom_rd);

  // R6
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(load_req || wr_req));

  // R9
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cur_chan <= LAST_CH);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !rom_rd && !tx_finish |=> $stable(cur_chan));
endmodule

// File: rtl/trim_word_gen.sv
module trim_word_gen
  import trim_pkg::*;
(
  input  logic [CH_W-1:0]    lch,
  input  logic [TRIM_DW-1:0] data,
  output logic [WORD_W-1:0]  word,
  output logic [1:0]         sel_first,
  output logic [1:0]         sel_last
);
  logic [PHYS_W-1:0] phys;

  assign phys      = trim_phys(lch);
  assign word      = trim_word(phys, data);
  assign sel_first = SEL_TRIM;
  assign sel_last  = SEL_MAIN0;
endmodule

// File: rtl/trim_readback.sv
module trim_readback
  import trim_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [CH_W-1:0]    widx,
  input  logic [TRIM_DW-1:0] wdata,
  input  logic [CH_W-1:0]    ridx,
  output logic [TRIM_DW-1:0] rdata
);
  logic [TRIM_DW-1:0] regs [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && widx == CH_W'(g))
        regs[g] <= wdata;
    end

    // R10
    slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we && widx == CH_W'(g) |=> regs[g] == $past(wdata));
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (ridx == CH_W'(i)) rdata = regs[i];
  end
endmodule

// File: rtl/trim_cal_loader.sv
module trim_cal_loader
  import trim_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_req,
  input  logic         wr_req,
  input  logic [3:0]   wr_chan,
  input  logic [7:0]   wr_data,
  output logic         busy,
  output logic         rom_rd,
  output logic [7:0]   rom_addr,
  input  logic         rom_valid,
  input  logic [7:0]   rom_rdata,
  output logic         tx_req,
  output logic [31:0]  tx_word,
  output logic [1:0]   tx_sel_first,
  output logic [1:0]   tx_sel_last,
  input  logic         tx_done,
  input  logic [3:0]   rb_sel,
  output logic [7:0]   rb_data
);
  logic [CH_W-1:0]    cur_chan;
  logic [TRIM_DW-1:0] cur_data;
  logic               rb_we;
  logic [CH_W-1:0]    rb_idx;
  logic [TRIM_DW-1:0] rb_din;

  trim_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (load_req),
    .wr_req    (wr_req),
    .wr_chan   (wr_chan),
    .wr_data   (wr_data),
    .rom_rd    (rom_rd),
    .rom_addr  (rom_addr),
    .rom_valid (rom_valid),
    .rom_rdata (rom_rdata),
    .tx_req    (tx_req),
    .tx_done   (tx_done),
    .cur_chan  (cur_chan),
    .cur_data  (cur_data),
    .busy      (busy),
    .rb_we     (rb_we),
    .rb_idx    (rb_idx),
    .rb_din    (rb_din)
  );

  trim_word_gen u_word (
    .lch       (cur_chan),
    .data      (cur_data),
    .word      (tx_word),
    .sel_first (tx_sel_first),
    .sel_last  (tx_sel_last)
  );

  trim_readback u_rb (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (rb_we),
    .widx  (rb_idx),
    .wdata (rb_din),
    .ridx  (rb_sel),
    .rdata (rb_data)
  );

  // R3
  word_phys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> tx_word[31:12] == '0 && tx_word[11:8] <= 4'd10);

  // R5
  no_read_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_rd && tx_req));

  // R8
  single_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !load_req && wr_req |=> !rom_rd);
endmodule

// File: tb/sim_trim_cal_loader.sv
module sim_trim_cal_loader;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        load_req = 0, wr_req = 0;
  logic [3:0]  wr_chan = 0;
  logic [7:0]  wr_data = 0;
  logic        busy, rom_rd, rom_valid = 0;
  logic [7:0]  rom_addr, rom_rdata = 0;
  logic        tx_req, tx_done = 0;
  logic [31:0] tx_word;
  logic [1:0]  tx_sel_first, tx_sel_last;
  logic [3:0]  rb_sel = 0;
  logic [7:0]  rb_data;

  always #2 clk = ~clk;

  trim_cal_loader u0 (.*);

  int errors = 0, checks = 0;
  logic [7:0]  eeprom [256];
  logic [31:0] tx_w [512];
  logic [1:0]  tx_sf [512], tx_sl [512];
  logic        tx_busy_after [512];
  logic [7:0]  rd_a [512];
  int tx_n = 0, rd_n = 0, rd_overlap = 0;
  logic [7:0]  shadow [11];

  localparam logic [43:0] PHYS_PACK =
    {4'd4, 4'd5, 4'd0, 4'd1, 4'd6, 4'd7, 4'd2, 4'd3, 4'd8, 4'd9, 4'd10};

  function automatic logic [3:0] b_phys(int i);
    return PHYS_PACK[i*4 +: 4];
  endfunction
  function automatic logic [7:0] b_addr(int i);
    if (i < 3) return 8'(8'h40 + i);
    if (i < 7) return 8'(8'h50 + i - 3);
    return 8'(8'h60 + i - 7);
  endfunction
  function automatic logic [31:0] b_word(int i, logic [7:0] d);
    return 32'(b_phys(i)) * 32'd256 + 32'(d);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model
  initial begin
    forever begin
      @(negedge clk);
      if (rom_rd) begin
        logic [7:0] a;
        a = rom_addr;
        rd_a[rd_n] = a;
        if (tx_req) rd_overlap++;
        rd_n++;
        repeat ($urandom_range(1, 3)) @(negedge clk);
        rom_valid = 1; rom_rdata = eeprom[a];
        @(negedge clk);
        rom_valid = 0; rom_rdata = 0;
      end
    end
  end

  // transmitter model
  initial begin
    forever begin
      @(negedge clk);
      if (tx_req) begin
        tx_w[tx_n] = tx_word; tx_sf[tx_n] = tx_sel_first; tx_sl[tx_n] = tx_sel_last;
        repeat ($urandom_range(0, 3)) begin
          @(negedge clk);
          if (tx_word != tx_w[tx_n])
            check(0, "R5", "word changed while held", tx_word, tx_w[tx_n]);
        end
        tx_done = 1;
        @(negedge clk);
        tx_done = 0;
        tx_busy_after[tx_n] = busy;
        if (tx_req) check(0, "R5", "tx_req after done", 1, 0);
        tx_n++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_rb(input string req);
    for (int i = 0; i < 11; i++) begin
      rb_sel = 4'(i); #1;
      check(rb_data == shadow[i], req, $sformatf("readback ch%0d", i), rb_data, shadow[i]);
    end
  endtask

  task automatic run_load(input bit inject);
    int t0, r0, o0;
    t0 = tx_n; r0 = rd_n; o0 = rd_overlap;
    @(negedge clk); load_req = 1;
    @(negedge clk); load_req = 0;
    check(busy == 1, "R6", "busy after load_req", busy, 1);
    if (inject) begin
      repeat (4) @(negedge clk);
      wr_req = 1; wr_chan = 4'd3; wr_data = 8'h5A; load_req = 1;
      @(negedge clk); wr_req = 0; load_req = 0;
    end
    wait_idle();
    check(tx_n - t0 == 11, "R6", "tx count per load", tx_n - t0, 11);
    check(rd_n - r0 == 11, "R7", "read count per load", rd_n - r0, 11);
    check(rd_overlap == o0, "R5", "read during open request", rd_overlap - o0, 0);
    for (int i = 0; i < 11; i++) begin
      logic [7:0] v;
      v = eeprom[b_addr(i)];
      shadow[i] = v;
      check(rd_a[r0+i] == b_addr(i), "R2", $sformatf("read address ch%0d", i), rd_a[r0+i], b_addr(i));
      check(tx_w[t0+i] == b_word(i, v), "R3", $sformatf("word ch%0d", i), tx_w[t0+i], b_word(i, v));
      check(tx_sf[t0+i] == 2'b01 && tx_sl[t0+i] == 2'b10, "R4", "select plan",
            {tx_sf[t0+i], tx_sl[t0+i]}, 4'b0110);
      check(tx_busy_after[t0+i] == (i != 10), "R6", $sformatf("busy after done %0d", i),
            tx_busy_after[t0+i], (i != 10));
    end
    check_rb("R10");
  endtask

  task automatic single_write(input logic [3:0] ch, input logic [7:0] d);
    int t0, r0;
    t0 = tx_n; r0 = rd_n;
    @(negedge clk); wr_req = 1; wr_chan = ch; wr_data = d;
    @(negedge clk); wr_req = 0;
    wait_idle();
    if (ch < 11) begin
      shadow[ch] = d;
      check(tx_n - t0 == 1, "R8", "single write tx count", tx_n - t0, 1);
      check(rd_n == r0, "R8", "single write read count", rd_n - r0, 0);
      check(tx_w[t0] == b_word(int'(ch), d), "R8", "single write word", tx_w[t0], b_word(int'(ch), d));
      check(tx_busy_after[t0] == 0, "R8", "busy after single", tx_busy_after[t0], 0);
      rb_sel = ch; #1;
      check(rb_data == d, "R10", "single write readback", rb_data, d);
    end else begin
      check(tx_n == t0, "R9", "bad channel tx count", tx_n - t0, 0);
      check(busy == 0, "R9", "bad channel busy", busy, 0);
      check_rb("R9");
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    for (int a = 0; a < 256; a++) eeprom[a] = 8'($urandom);
    for (int i = 0; i < 11; i++) shadow[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(busy == 0 && rom_rd == 0 && tx_req == 0, "R1", "reset outputs",
          {busy, rom_rd, tx_req}, 0);
    check_rb("R1");
    rst_n = 1;
    repeat (2) @(negedge clk);

    run_load(0);
    for (int i = 0; i < 11; i++) eeprom[b_addr(i)] = (i % 2 == 0) ? 8'hFF : 8'h00;
    run_load(1);   // R7: requests arriving while busy
    single_write(4'd0, 8'h00);
    single_write(4'd10, 8'hFF);
    for (int k = 0; k < 20; k++)
      single_write(4'($urandom_range(0, 10)), 8'($urandom));
    single_write(4'd11, 8'hA5);
    single_write(4'd15, 8'h3C);
    rb_sel = 4'd13; #1;
    check(rb_data == 0, "R10", "out-of-range select", rb_data, 0);
    for (int a = 0; a < 256; a++) eeprom[a] = 8'($urandom);
    run_load(0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule